// File: doc/BRIEF.md
# Coherence Access-Rights Filter Cache

This block keeps a small direct-mapped table of per-line access rights next to a processor bus. Each bus request gives a physical address and says whether it reads or writes. One cycle later the block answers whether the operation may go ahead, must be postponed because the node lacks the rights, or missed because the table holds nothing for that line. The table works on 64-byte lines, so the six low address bits play no part in the lookup.

A coherency controller owns the table's contents through an update port. The same write installs a line, upgrades its rights or downgrades them. Before the local processor may finish a read of a line that was modified elsewhere, the controller sets the line to read-only. Before the node starts work that remote agents could use to invalidate its copy, the controller drops the line to no access. A separate check port lets the controller compare the protocol state it holds with what the table caches. Any disagreement raises a panic that stays set until reset and records what went wrong.

Top module: `arf_filter`

## Requirements
- R1: Reset clears every valid bit and the panic record. After reset, every lookup answers miss, `panic` is low and `rsp_valid` is low.
- R2: A request sampled with `req_valid` high yields `rsp_valid` high on the next cycle, with `rsp_code` 00 = allow, 01 = postpone, 10 = miss. Without a request, `rsp_valid` is low.
- R3: The slot index is address bits [6+log2(ENTRIES)-1:6] and the tag is the bits above them. Bits [5:0] are ignored. A lookup whose slot is invalid, or holds a different tag, answers miss.
- R4: Rights codes are 00 no access, 01 read-only, 11 full, and 10 reserved. A read is allowed under 01 or 11. A write is allowed only under 11. Every other hit answers postpone.
- R5: An update writes valid, tag and rights into the indexed slot and replaces any line held there. Lookups from the next cycle on see the new contents.
- R6: When an update and a lookup name the same line in the same cycle, the lookup answers postpone.
- R7: A check whose line hits in the table, with `chk_state` (same coding as R4) different from the cached rights, raises `panic` on the next cycle. A check that matches, or that misses, leaves `panic` low.
- R8: A lookup that hits a slot holding the reserved code 10 answers postpone and raises `panic`. It records cached = 10 and auth = 10.
- R9: `panic` stays high until reset. `panic_line` (address bits above bit 5), `panic_cached` and `panic_auth` hold the first failure, and later failures do not change them. A check failure wins over a reserved-code lookup failure in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor lookup request |
| req_addr | input | ADDR_W | Request physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_code | output | 2 | 00 allow, 01 postpone, 10 miss |
| upd_valid | input | 1 | Controller writes an entry |
| upd_addr | input | ADDR_W | Address of the line to write |
| upd_rights | input | 2 | Rights code to store |
| chk_valid | input | 1 | Controller cross-check request |
| chk_addr | input | ADDR_W | Address of the line to check |
| chk_state | input | 2 | Authoritative rights for the line |
| panic | output | 1 | Sticky mismatch flag |
| panic_line | output | ADDR_W-6 | Line address of the first failure |
| panic_cached | output | 2 | Cached rights at the first failure |
| panic_auth | output | 2 | Authoritative rights at the first failure (10 for a lookup failure) |

## Verification
The assertions assume that `chk_state` never carries the reserved code 10. They also assume that requests, updates and checks are held steady for the whole cycle in which they are sampled, and are single-cycle events with no handshake. The stimulus changes inputs only on the falling clock edge and drops every valid strobe once it has been sampled. Reserved codes enter the table only through a deliberate update, so that the R8 path is exercised on purpose.

// File: rtl/arf_pkg.sv
package arf_pkg;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_READ = 2'b01,
    RT_RSV  = 2'b10,
    RT_FULL = 2'b11
  } rights_t;

  typedef enum logic [1:0] {
    RSP_ALLOW = 2'b00,
    RSP_WAIT  = 2'b01,
    RSP_MISS  = 2'b10
  } rsp_t;

  // Sufficiency of cached rights for one bus operation.
  function automatic logic rights_permit(input rights_t r, input logic is_write);
    case (r)
      RT_FULL: rights_permit = 1'b1;
      RT_READ: rights_permit = !is_write;
      default: rights_permit = 1'b0;
    endcase
  endfunction

  // Final response for a lookup, given the slot outcome.
  function automatic rsp_t decide_rsp(input logic collide, input logic hit,
                                      input rights_t r, input logic is_write);
    if (collide)                       decide_rsp = RSP_WAIT;
    else if (!hit)                     decide_rsp = RSP_MISS;
    else if (rights_permit(r, is_write)) decide_rsp = RSP_ALLOW;
    else                               decide_rsp = RSP_WAIT;
  endfunction

endpackage

// File: rtl/arf_rights_store.sv
module arf_rights_store
  import arf_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int TAG_W   = 26,
  parameter int NRD     = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [1:0]                 wr_rights,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  input  logic [NRD-1:0][TAG_W-1:0]  rd_tag,
  output logic [NRD-1:0]             rd_hit,
  output logic [NRD-1:0][1:0]        rd_rights
);

  logic             ent_valid  [ENTRIES];
  logic [TAG_W-1:0] ent_tag    [ENTRIES];
  logic [1:0]       ent_rights [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_valid[i] <= 1'b0;
    end else if (wr_en) begin
      ent_valid[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_tag[wr_idx]    <= wr_tag;
      ent_rights[wr_idx] <= wr_rights;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_hit[p]    = ent_valid[rd_idx[p]] && (ent_tag[rd_idx[p]] == rd_tag[p]);
    assign rd_rights[p] = ent_rights[rd_idx[p]];
  end

  // R5: a written slot is valid and holds the written code on the next cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_valid[$past(wr_idx)] && (ent_rights[$past(wr_idx)] == $past(wr_rights)));

endmodule

// File: rtl/arf_decide.sv
module arf_decide
  import arf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       hit,
  input  logic [1:0] rights,
  input  logic       collide,
  output logic       rsp_valid,
  output logic [1:0] rsp_code,
  output logic       rsv_hit
);

  rsp_t rsp_d;
  rsp_t rsp_q;
  logic vld_q;

  always_comb begin
    rsp_d = decide_rsp(collide, hit, rights_t'(rights), req_write);
  end

  assign rsv_hit = req_valid && hit && (rights_t'(rights) == RT_RSV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rsp_q <= RSP_MISS;
    end else begin
      vld_q <= req_valid;
      if (req_valid) rsp_q <= rsp_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_code  = rsp_q;

  // R2: one response per request, exactly one cycle later
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3: no slot hit and no collision means miss
  a_r3_miss_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && !collide) |=> (rsp_code == RSP_MISS));
  // R4: a write is never allowed unless full rights are cached
  a_r4_write_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && rights != 2'b11) |=> (rsp_code != RSP_ALLOW));
  // R6: same-line update in the same cycle forces postpone
  a_r6_collide_postpones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && collide) |=> (rsp_code == RSP_WAIT));

endmodule

// File: rtl/arf_panic_latch.sv
module arf_panic_latch #(
  parameter int LINE_W = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_fail,
  input  logic [LINE_W-1:0] chk_line,
  input  logic [1:0]        chk_cached,
  input  logic [1:0]        chk_auth,
  input  logic              rsv_fail,
  input  logic [LINE_W-1:0] rsv_line,
  output logic              panic,
  output logic [LINE_W-1:0] panic_line,
  output logic [1:0]        panic_cached,
  output logic [1:0]        panic_auth
);

  logic fail_any;
  assign fail_any = chk_fail || rsv_fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      panic        <= 1'b0;
      panic_line   <= '0;
      panic_cached <= 2'b00;
      panic_auth   <= 2'b00;
    end else if (!panic && fail_any) begin
      panic <= 1'b1;
      if (chk_fail) begin
        panic_line   <= chk_line;
        panic_cached <= chk_cached;
        panic_auth   <= chk_auth;
      end else begin
        panic_line   <= rsv_line;
        panic_cached <= 2'b10;
        panic_auth   <= 2'b10;
      end
    end
  end

  // R9: panic never clears and its record never moves while set
  a_r9_panic_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    panic |=> panic);
  a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    panic |=> ($stable(panic_line) && $stable(panic_cached) && $stable(panic_auth)));
  // R8: a reserved-code lookup alone records the 10 marker
  a_r8_rsv_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (!panic && rsv_fail && !chk_fail) |=> (panic && panic_auth == 2'b10));

endmodule

// File: rtl/arf_filter.sv
module arf_filter
  import arf_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int ADDR_W  = 40,
  localparam int OFS_W  = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINE_W = ADDR_W - OFS_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [1:0]        upd_rights,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [1:0]        chk_state,
  output logic              panic,
  output logic [LINE_W-1:0] panic_line,
  output logic [1:0]        panic_cached,
  output logic [1:0]        panic_auth
);

  localparam int RD_REQ = 0;
  localparam int RD_CHK = 1;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    line_of = a[ADDR_W-1:OFS_W];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    idx_of = a[OFS_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    tag_of = a[ADDR_W-1 -: TAG_W];
  endfunction

  logic unused_offset_bits;
  assign unused_offset_bits = ^{req_addr[OFS_W-1:0], upd_addr[OFS_W-1:0], chk_addr[OFS_W-1:0]};

  logic [1:0][IDX_W-1:0] rd_idx;
  logic [1:0][TAG_W-1:0] rd_tag;
  logic [1:0]            rd_hit;
  logic [1:0][1:0]       rd_rights;

  assign rd_idx[RD_REQ] = idx_of(req_addr);
  assign rd_tag[RD_REQ] = tag_of(req_addr);
  assign rd_idx[RD_CHK] = idx_of(chk_addr);
  assign rd_tag[RD_CHK] = tag_of(chk_addr);

  arf_rights_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .NRD(2)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (upd_valid),
    .wr_idx    (idx_of(upd_addr)),
    .wr_tag    (tag_of(upd_addr)),
    .wr_rights (upd_rights),
    .rd_idx    (rd_idx),
    .rd_tag    (rd_tag),
    .rd_hit    (rd_hit),
    .rd_rights (rd_rights)
  );

  // Named events for the assertions
  logic same_line_collide;
  logic chk_mismatch;
  logic rsv_hit;

  assign same_line_collide = upd_valid && req_valid && (line_of(upd_addr) == line_of(req_addr));
  assign chk_mismatch      = chk_valid && rd_hit[RD_CHK] && (rd_rights[RD_CHK] != chk_state);

  arf_decide u_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .hit       (rd_hit[RD_REQ]),
    .rights    (rd_rights[RD_REQ]),
    .collide   (same_line_collide),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsv_hit   (rsv_hit)
  );

  arf_panic_latch #(.LINE_W(LINE_W)) u_panic (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_fail     (chk_mismatch),
    .chk_line     (line_of(chk_addr)),
    .chk_cached   (rd_rights[RD_CHK]),
    .chk_auth     (chk_state),
    .rsv_fail     (rsv_hit),
    .rsv_line     (line_of(req_addr)),
    .panic        (panic),
    .panic_line   (panic_line),
    .panic_cached (panic_cached),
    .panic_auth   (panic_auth)
  );

  // R7: a mismatching check always leaves panic set next cycle
  a_r7_mismatch_panics: assert property (@(posedge clk) disable iff (!rst_n)
    chk_mismatch |=> panic);
  // R7: a first panic is only ever caused by a check or reserved-code lookup
  a_r7_panic_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!panic && !chk_mismatch && !rsv_hit) |=> !panic);
  // R8: reserved-code lookups are never allowed
  a_r8_rsv_postpones: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_hit |=> (rsp_code == RSP_WAIT));

endmodule

// File: tb/arf_filter_bench.sv
module arf_filter_bench;

  localparam int ADDR_W = 40;
  localparam int LINE_W = ADDR_W - 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              rsp_valid;
  logic [1:0]        rsp_code;
  logic              upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic [1:0]        upd_rights = 2'b00;
  logic              chk_valid = 1'b0;
  logic [ADDR_W-1:0] chk_addr = '0;
  logic [1:0]        chk_state = 2'b00;
  logic              panic;
  logic [LINE_W-1:0] panic_line;
  logic [1:0]        panic_cached;
  logic [1:0]        panic_auth;

  arf_filter u_arf_filter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_rights(upd_rights),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_state(chk_state),
    .panic(panic), .panic_line(panic_line),
    .panic_cached(panic_cached), .panic_auth(panic_auth)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  localparam logic [1:0] ALLOW = 2'b00, WAIT = 2'b01, MISS = 2'b10;
  localparam logic [ADDR_W-1:0] A_LINE = 40'h00_0000_1000; // slot 64
  localparam logic [ADDR_W-1:0] B_LINE = 40'h00_0000_5000; // slot 64, other tag
  localparam logic [ADDR_W-1:0] C_LINE = 40'h02_0000_0080;

  task automatic expect_eq(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus: drive at falling edge, sample just after rising edge.
  task automatic cycle(input logic rv, input logic [ADDR_W-1:0] ra, input logic rw,
                       input logic uv, input logic [ADDR_W-1:0] ua, input logic [1:0] ur,
                       input logic cv, input logic [ADDR_W-1:0] ca, input logic [1:0] cs);
    @(negedge clk);
    req_valid = rv; req_addr = ra; req_write = rw;
    upd_valid = uv; upd_addr = ua; upd_rights = ur;
    chk_valid = cv; chk_addr = ca; chk_state = cs;
    @(posedge clk);
    #1;
    req_valid = 1'b0; upd_valid = 1'b0; chk_valid = 1'b0;
  endtask

  task automatic lookup(input logic [ADDR_W-1:0] a, input logic wr,
                        input logic [1:0] exp, input string req);
    cycle(1'b1, a, wr, 1'b0, '0, 2'b00, 1'b0, '0, 2'b00);
    expect_eq(req, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
    expect_eq(req, "rsp_code", {62'd0, rsp_code}, {62'd0, exp});
  endtask

  task automatic update(input logic [ADDR_W-1:0] a, input logic [1:0] r);
    cycle(1'b0, '0, 1'b0, 1'b1, a, r, 1'b0, '0, 2'b00);
  endtask

  task automatic check(input logic [ADDR_W-1:0] a, input logic [1:0] s);
    cycle(1'b0, '0, 1'b0, 1'b0, '0, 2'b00, 1'b1, a, s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Vector fields: [47:46] kind (0 update, 1 lookup), [45:44] expected code,
  // [43:42] rights, [41] write, [40] spare, [39:0] address.
  localparam int NVEC = 14;
  localparam logic [47:0] VEC [NVEC] = '{
    {2'd1, MISS,  2'b00, 1'b0, 1'b0, A_LINE},           // R1 empty after reset
    {2'd0, ALLOW, 2'b11, 1'b0, 1'b0, A_LINE},           // install full
    {2'd1, ALLOW, 2'b00, 1'b0, 1'b0, A_LINE},           // R4 read under full
    {2'd1, ALLOW, 2'b00, 1'b1, 1'b0, A_LINE},           // R4 write under full
    {2'd0, ALLOW, 2'b01, 1'b0, 1'b0, A_LINE},           // downgrade to read-only
    {2'd1, ALLOW, 2'b00, 1'b0, 1'b0, A_LINE},           // R4 read under read-only
    {2'd1, WAIT,  2'b00, 1'b1, 1'b0, A_LINE},           // R4 write under read-only
    {2'd1, WAIT,  2'b00, 1'b1, 1'b0, A_LINE | 40'h3F},  // R3 offset bits ignored
    {2'd0, ALLOW, 2'b00, 1'b0, 1'b0, A_LINE},           // downgrade to none
    {2'd1, WAIT,  2'b00, 1'b0, 1'b0, A_LINE},           // R4 read under none
    {2'd1, MISS,  2'b00, 1'b0, 1'b0, B_LINE},           // R3 tag mismatch
    {2'd0, ALLOW, 2'b11, 1'b0, 1'b0, B_LINE},           // R5 replace slot
    {2'd1, MISS,  2'b00, 1'b0, 1'b0, A_LINE},           // R5 old line gone
    {2'd1, ALLOW, 2'b00, 1'b1, 1'b0, B_LINE}            // R5 new line live
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    expect_eq("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    expect_eq("R1", "panic after reset", {63'd0, panic}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][47:46] == 2'd0) update(VEC[i][39:0], VEC[i][43:42]);
      else lookup(VEC[i][39:0], VEC[i][41], VEC[i][45:44], "R2/R3/R4/R5 vector");
    end

    // R2: idle cycle gives no response
    cycle(1'b0, '0, 1'b0, 1'b0, '0, 2'b00, 1'b0, '0, 2'b00);
    expect_eq("R2", "rsp_valid idle", {63'd0, rsp_valid}, 64'd0);

    // R6: same-line update and lookup in one cycle -> postpone, then new rights seen
    cycle(1'b1, A_LINE | 40'h8, 1'b0, 1'b1, A_LINE, 2'b01, 1'b0, '0, 2'b00);
    expect_eq("R6", "collide rsp_code", {62'd0, rsp_code}, {62'd0, WAIT});
    lookup(A_LINE, 1'b0, ALLOW, "R5 after collide");

    // R6 negative: update of another line does not force postpone
    cycle(1'b1, A_LINE, 1'b0, 1'b1, C_LINE, 2'b11, 1'b0, '0, 2'b00);
    expect_eq("R6", "no collide other line", {62'd0, rsp_code}, {62'd0, ALLOW});

    // R7: matching check and missing check leave panic low
    check(A_LINE, 2'b01);
    expect_eq("R7", "panic on match", {63'd0, panic}, 64'd0);
    check(B_LINE, 2'b00);
    expect_eq("R7", "panic on miss", {63'd0, panic}, 64'd0);

    // R7: mismatch (table read-only, authority full) raises panic
    check(A_LINE, 2'b11);
    expect_eq("R7", "panic on mismatch", {63'd0, panic}, 64'd1);
    expect_eq("R9", "panic_line", {30'd0, panic_line}, {30'd0, A_LINE[39:6]});
    expect_eq("R9", "panic_cached", {62'd0, panic_cached}, 64'd1);
    expect_eq("R9", "panic_auth", {62'd0, panic_auth}, 64'd3);

    // R9: a second failure changes nothing
    check(C_LINE, 2'b00);
    expect_eq("R9", "panic stays", {63'd0, panic}, 64'd1);
    expect_eq("R9", "panic_line kept", {30'd0, panic_line}, {30'd0, A_LINE[39:6]});
    expect_eq("R9", "panic_cached kept", {62'd0, panic_cached}, 64'd1);

    // R1: reset clears panic and entries
    do_reset();
    @(posedge clk);
    #1;
    expect_eq("R1", "panic cleared", {63'd0, panic}, 64'd0);
    lookup(A_LINE, 1'b0, MISS, "R1 entry cleared");

    // R8: reserved code read by a lookup
    update(C_LINE, 2'b10);
    lookup(C_LINE, 1'b0, WAIT, "R8 reserved postpones");
    expect_eq("R8", "panic on reserved", {63'd0, panic}, 64'd1);
    expect_eq("R8", "panic_line", {30'd0, panic_line}, {30'd0, C_LINE[39:6]});
    expect_eq("R8", "panic_cached", {62'd0, panic_cached}, 64'd2);
    expect_eq("R8", "panic_auth", {62'd0, panic_auth}, 64'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule